// File: doc/BRIEF.md
# Two-Event Classification Sequence Detector

This block sits on the powered-device side of a Power-over-Ethernet link and watches a stream of digitized port-voltage samples, each an unsigned code in 100 mV units. Every accepted sample is sorted into a voltage band. A band takes effect only after several consecutive valid samples agree. From the settled bands the block tracks the link region (reset, detection, classification, mark or power) and counts classification events that are properly closed by a mark event.

When the port voltage reaches the power band, the block captures whether the supply equipment completed the two-pair finger/mark handshake. Two pairs mark a high-power source, and fewer leave it as a basic source. The block then drives an active-low indicator once the downstream converter reports its output as powered. A dip into the reset band at any point throws away all handshake progress. After that, the supply equipment has to repeat the full sequence before the high-power result can return.

Top module: `pd_class_seq_detect`

## Requirements
- R1: During and right after reset, region_o is 0 (reset region), mark_cnt_o is 0, src_hp_o is 0 and hp_ind_n_o is 1.
- R2: A voltage code falls into one of six bands. LOW is below 54. MID runs from 54 to 97. GAP runs from 98 to 129. CLASS runs from 130 to 205. HIGH runs from 206 to 379. POWER is 380 or more. Region codes on region_o are 0 for reset, 1 for detection, 2 for classification, 3 for mark and 4 for power.
- R3: A new band settles on the clock edge that captures the third consecutive valid sample in that band. The outputs change on that same edge. Samples with smp_vld low neither count toward nor break a run, and a valid sample in a different band restarts the run.
- R4: A CLASS band settled from a lower band (LOW, MID or GAP) arms an event, and region_o becomes 2. When MID later settles while the event is armed, possibly after passing through GAP, mark_cnt_o rises by one and region_o becomes 3. MID without an armed event gives region 1, or keeps region 3 if the region is already 3. GAP and HIGH give region 1.
- R5: mark_cnt_o saturates at 2, so any further finger/mark pairs leave it at 2.
- R6: A settled LOW band sets region_o to 0, clears mark_cnt_o to 0, drops any armed event and clears the captured type, from any region.
- R7: Outside the power region, src_hp_o is 1 exactly when mark_cnt_o is 2. Settling the POWER band sets region_o to 4 and captures that value, and src_hp_o then holds the captured value while the region stays 4.
- R8: hp_ind_n_o is 0 exactly when region_o is 4, the captured type is high-power and conv_pwr is 1. It is 1 at all other times.
- R9: While region_o is 4, only a settled LOW band changes the region or the count. All other bands are ignored.
- R10: A CLASS band entered from HIGH (from above) is not armed and is never counted, and settling HIGH discards any armed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Voltage sample valid strobe |
| smp_code | input | VW (10) | Port voltage, unsigned, 100 mV per step |
| conv_pwr | input | 1 | Downstream converter output is powered |
| region_o | output | 3 | Current region code |
| mark_cnt_o | output | CW (2) | Count of completed finger/mark pairs |
| src_hp_o | output | 1 | Supply type: 1 high-power, 0 basic |
| hp_ind_n_o | output | 1 | Active-low high-power indicator |

## Verification
A wrong filter state moves region_o one or more edges early or late relative to the third agreeing sample, so the bench catches it on the first band change that follows. A stale armed flag or a miscounted pair shows up in mark_cnt_o at the next settled MID band, and shows up as src_hp_o and hp_ind_n_o values that disagree at power entry. A broken freeze or a broken reset path appears as a change of src_hp_o during power, or as a count that survives a LOW band, within three samples of the offending stimulus.

// File: rtl/pd_cls_pkg.sv
package pd_cls_pkg;

  typedef enum logic [2:0] {
    BAND_LOW  = 3'd0,
    BAND_MID  = 3'd1,
    BAND_GAP  = 3'd2,
    BAND_CLS  = 3'd3,
    BAND_HIGH = 3'd4,
    BAND_PWR  = 3'd5
  } band_e;

  typedef enum logic [2:0] {
    RGN_RESET  = 3'd0,
    RGN_DETECT = 3'd1,
    RGN_CLASS  = 3'd2,
    RGN_MARK   = 3'd3,
    RGN_POWER  = 3'd4
  } region_e;

  // Map an unsigned voltage code onto its band.
  function automatic band_e band_of(input int unsigned code,
                                    input int unsigned mark_lo,
                                    input int unsigned mark_hi,
                                    input int unsigned cls_lo,
                                    input int unsigned cls_hi,
                                    input int unsigned pwr_on);
    band_e b;
    if (code >= pwr_on)       b = BAND_PWR;
    else if (code > cls_hi)   b = BAND_HIGH;
    else if (code >= cls_lo)  b = BAND_CLS;
    else if (code > mark_hi)  b = BAND_GAP;
    else if (code >= mark_lo) b = BAND_MID;
    else                      b = BAND_LOW;
    return b;
  endfunction

  // A band lies below the classification band.
  function automatic logic below_class(input band_e b);
    return (b == BAND_LOW) || (b == BAND_MID) || (b == BAND_GAP);
  endfunction

  // Saturating increment of the pair count.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/pd_band_filter.sv
module pd_band_filter
  import pd_cls_pkg::*;
#(
  parameter int VW      = 10,
  parameter int AGREE   = 3,
  parameter int MARK_LO = 54,
  parameter int MARK_HI = 97,
  parameter int CLS_LO  = 130,
  parameter int CLS_HI  = 205,
  parameter int PWR_ON  = 380
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [VW-1:0] smp_code,
  output band_e         cur_band,
  output band_e         new_band,
  output logic          band_chg
);
  localparam int RW = $clog2(AGREE + 1);

  band_e         cand_q, cand_d, settled_q, raw_band;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    raw_band = band_of(32'(smp_code), MARK_LO, MARK_HI, CLS_LO, CLS_HI, PWR_ON);
    cand_d   = cand_q;
    run_d    = run_q;
    if (smp_vld) begin
      if (raw_band == cand_q) begin
        run_d = (run_q == RW'(AGREE)) ? run_q : run_q + 1'b1;
      end else begin
        cand_d = raw_band;
        run_d  = RW'(1);
      end
    end
  end

  assign band_chg = smp_vld && (run_d == RW'(AGREE)) && (cand_d != settled_q);
  assign new_band = cand_d;
  assign cur_band = settled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q    <= BAND_LOW;
      run_q     <= RW'(AGREE);
      settled_q <= BAND_LOW;
    end else begin
      cand_q <= cand_d;
      run_q  <= run_d;
      if (band_chg) settled_q <= cand_d;
    end
  end

  // R3
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(settled_q));

  // R3
  filter_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled_q != $past(settled_q)) |-> ($past(smp_vld) && (cand_q == settled_q)));

endmodule

// File: rtl/pd_region_fsm.sv
module pd_region_fsm
  import pd_cls_pkg::*;
#(
  parameter int CNT_MAX = 2,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          band_chg,
  input  band_e         new_band,
  input  band_e         cur_band,
  output region_e       region,
  output logic [CW-1:0] pair_cnt,
  output logic          hp_frozen,
  output logic          evt_armed
);
  region_e       rgn_d;
  logic [CW-1:0] cnt_d;
  logic          frz_d, arm_d;
  logic          low_hit;

  assign low_hit = band_chg && (new_band == BAND_LOW);

  always_comb begin
    rgn_d = region;
    cnt_d = pair_cnt;
    frz_d = hp_frozen;
    arm_d = evt_armed;
    if (low_hit) begin
      rgn_d = RGN_RESET;
      cnt_d = '0;
      frz_d = 1'b0;
      arm_d = 1'b0;
    end else if (band_chg && region != RGN_POWER) begin
      unique case (new_band)
        BAND_MID: begin
          if (evt_armed) begin
            cnt_d = CW'(sat_inc(32'(pair_cnt), CNT_MAX));
            arm_d = 1'b0;
            rgn_d = RGN_MARK;
          end else if (region != RGN_MARK) begin
            rgn_d = RGN_DETECT;
          end
        end
        BAND_GAP: rgn_d = RGN_DETECT;
        BAND_CLS: begin
          rgn_d = RGN_CLASS;
          arm_d = below_class(cur_band);
        end
        BAND_HIGH: begin
          rgn_d = RGN_DETECT;
          arm_d = 1'b0;
        end
        BAND_PWR: begin
          rgn_d = RGN_POWER;
          frz_d = (pair_cnt == CW'(CNT_MAX));
          arm_d = 1'b0;
        end
        default: rgn_d = region;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region    <= RGN_RESET;
      pair_cnt  <= '0;
      hp_frozen <= 1'b0;
      evt_armed <= 1'b0;
    end else begin
      region    <= rgn_d;
      pair_cnt  <= cnt_d;
      hp_frozen <= frz_d;
      evt_armed <= arm_d;
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_cnt != $past(pair_cnt)) |-> ((pair_cnt == $past(pair_cnt) + 1'b1) || (pair_cnt == '0)));

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_cnt <= CW'(CNT_MAX));

  // R6
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_hit |=> (region == RGN_RESET) && (pair_cnt == '0));

  // R9
  power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_POWER) && !low_hit |=> (region == RGN_POWER) && $stable(pair_cnt));

  // R7
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_POWER) && ($past(region) == RGN_POWER) |-> $stable(hp_frozen));

endmodule

// File: rtl/pd_class_seq_detect.sv
module pd_class_seq_detect
  import pd_cls_pkg::*;
#(
  parameter int VW      = 10,
  parameter int AGREE   = 3,
  parameter int MARK_LO = 54,
  parameter int MARK_HI = 97,
  parameter int CLS_LO  = 130,
  parameter int CLS_HI  = 205,
  parameter int PWR_ON  = 380,
  parameter int CNT_MAX = 2,
  localparam int CW     = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [VW-1:0] smp_code,
  input  logic          conv_pwr,
  output logic [2:0]    region_o,
  output logic [CW-1:0] mark_cnt_o,
  output logic          src_hp_o,
  output logic          hp_ind_n_o
);
  band_e         cur_band, new_band;
  logic          band_chg;
  region_e       region;
  logic [CW-1:0] pair_cnt;
  logic          hp_frozen, evt_armed;
  logic          in_power;

  pd_band_filter #(
    .VW(VW), .AGREE(AGREE), .MARK_LO(MARK_LO), .MARK_HI(MARK_HI),
    .CLS_LO(CLS_LO), .CLS_HI(CLS_HI), .PWR_ON(PWR_ON)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .cur_band(cur_band), .new_band(new_band), .band_chg(band_chg)
  );

  pd_region_fsm #(.CNT_MAX(CNT_MAX), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .band_chg(band_chg), .new_band(new_band),
    .cur_band(cur_band), .region(region), .pair_cnt(pair_cnt),
    .hp_frozen(hp_frozen), .evt_armed(evt_armed)
  );

  assign in_power   = (region == RGN_POWER);
  assign region_o   = region;
  assign mark_cnt_o = pair_cnt;
  assign src_hp_o   = in_power ? hp_frozen : (pair_cnt == CW'(CNT_MAX));
  assign hp_ind_n_o = !(in_power && hp_frozen && conv_pwr);

  // R8
  ind_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_ind_n_o |-> (region_o == 3'd4) && conv_pwr && src_hp_o);

  // R7
  type_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o == 3'd4) && ($past(region_o) == 3'd4) |-> $stable(src_hp_o));

  // R4
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_cnt_o != $past(mark_cnt_o)) && (mark_cnt_o != '0) |-> (region_o == 3'd3));

endmodule

// File: tb/pd_class_seq_detect_bench.sv
module pd_class_seq_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic [9:0] smp_code = '0;
  logic       conv_pwr = 1'b0;
  logic [2:0] region_o;
  logic [1:0] mark_cnt_o;
  logic       src_hp_o, hp_ind_n_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_cand = 0, m_run = 3, m_set = 0, m_rgn = 0, m_cnt = 0;
  bit m_pend = 0, m_frz = 0;

  always #5 clk = ~clk;

  pd_class_seq_detect u_pd_class_seq_detect (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .conv_pwr(conv_pwr), .region_o(region_o), .mark_cnt_o(mark_cnt_o),
    .src_hp_o(src_hp_o), .hp_ind_n_o(hp_ind_n_o)
  );

  // band numbers: 0 low, 1 mid, 2 gap, 3 class, 4 high, 5 power (R2)
  function automatic int ref_band(input int v);
    int b;
    b = 0;
    if (v >= 54)  b = 1;
    if (v >= 98)  b = 2;
    if (v >= 130) b = 3;
    if (v >= 206) b = 4;
    if (v >= 380) b = 5;
    return b;
  endfunction

  task automatic ref_apply(input int b, input int prev);
    if (b == 0) begin
      m_rgn = 0; m_cnt = 0; m_pend = 0; m_frz = 0;
    end else if (m_rgn != 4) begin
      case (b)
        1: if (m_pend) begin
             m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2; m_pend = 0; m_rgn = 3;
           end else if (m_rgn != 3) m_rgn = 1;
        2: m_rgn = 1;
        3: begin m_rgn = 2; m_pend = (prev < 3); end
        4: begin m_rgn = 1; m_pend = 0; end
        default: begin m_rgn = 4; m_frz = (m_cnt == 2); m_pend = 0; end
      endcase
    end
  endtask

  task automatic ref_clock();
    int b, prev;
    if (!rst_n) begin
      m_cand = 0; m_run = 3; m_set = 0; m_rgn = 0; m_cnt = 0; m_pend = 0; m_frz = 0;
    end else if (smp_vld) begin
      b = ref_band(int'(smp_code));
      if (b == m_cand) m_run = (m_run < 3) ? m_run + 1 : 3;
      else begin m_cand = b; m_run = 1; end
      if (m_run == 3 && m_cand != m_set) begin
        prev = m_set; m_set = m_cand; ref_apply(m_cand, prev);
      end
    end
  endtask

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int e_hp, e_ind;
    e_hp  = (m_rgn == 4) ? int'(m_frz) : int'(m_cnt == 2);
    e_ind = (m_rgn == 4 && m_frz && conv_pwr) ? 0 : 1;
    check1(tag, "region", int'(region_o), m_rgn);
    check1(tag, "count", int'(mark_cnt_o), m_cnt);
    check1(tag, "type", int'(src_hp_o), e_hp);
    check1(tag, "indicator", int'(hp_ind_n_o), e_ind);
  endtask

  task automatic step(input bit v, input int c, input bit p, input string tag);
    smp_vld = v; smp_code = c[9:0]; conv_pwr = p;
    @(posedge clk);
    ref_clock();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic hold(input int c, input int n, input bit p, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, c, p, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // R1 reset state
    step(1'b1, 450, 1'b1, "R1");
    step(1'b1, 450, 1'b1, "R1");
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, "R1");

    // R4 R5 R7 R8: three finger/mark pairs, then power
    hold(20, 4, 0, "R2");
    hold(80, 4, 0, "R4");
    hold(160, 4, 0, "R4");
    hold(80, 4, 0, "R4");
    hold(160, 4, 0, "R4");
    hold(80, 4, 0, "R7");
    hold(160, 4, 0, "R5");
    hold(80, 4, 0, "R5");
    hold(450, 4, 0, "R7");
    hold(450, 3, 1, "R8");
    // R9 bands other than low ignored in power
    hold(160, 4, 1, "R9");
    hold(80, 4, 1, "R9");
    hold(300, 4, 1, "R9");
    // R6 low band resets
    hold(20, 4, 1, "R6");

    // R3 noise and invalid samples
    hold(80, 4, 0, "R3");
    step(1'b1, 160, 0, "R3");
    step(1'b1, 160, 0, "R3");
    step(1'b1, 80, 0, "R3");
    step(1'b1, 160, 0, "R3");
    step(1'b0, 450, 0, "R3");
    step(1'b1, 160, 0, "R3");
    step(1'b0, 20, 0, "R3");
    step(1'b1, 160, 0, "R3");
    step(1'b1, 110, 0, "R3");
    hold(110, 3, 0, "R3");
    hold(80, 4, 0, "R3");

    // single event: basic source, indicator stays high
    hold(450, 4, 1, "R8");
    hold(30, 4, 0, "R6");

    // R6 reset crossing between events cancels progress
    hold(80, 3, 0, "R6");
    hold(160, 3, 0, "R6");
    hold(80, 3, 0, "R6");
    hold(40, 3, 0, "R6");
    hold(80, 3, 0, "R6");
    hold(160, 3, 0, "R6");
    hold(80, 3, 0, "R6");
    hold(400, 4, 1, "R6");
    hold(0, 4, 0, "R6");

    // R10 class entered from above is not counted
    hold(80, 3, 0, "R10");
    hold(300, 3, 0, "R10");
    hold(160, 3, 0, "R10");
    hold(80, 3, 0, "R10");
    // armed event discarded by high band
    hold(110, 3, 0, "R10");
    hold(160, 3, 0, "R10");
    hold(250, 3, 0, "R10");
    hold(80, 3, 0, "R10");

    // R2 band edges
    hold(53, 3, 0, "R2");
    hold(54, 3, 0, "R2");
    hold(129, 3, 0, "R2");
    hold(130, 3, 0, "R2");
    hold(97, 3, 0, "R2");
    hold(98, 3, 0, "R2");
    hold(205, 3, 0, "R2");
    hold(206, 3, 0, "R2");
    hold(130, 3, 0, "R2");
    hold(54, 3, 0, "R2");
    hold(130, 3, 0, "R2");
    hold(97, 3, 0, "R2");
    hold(379, 3, 0, "R2");
    hold(380, 3, 1, "R2");
    hold(53, 3, 0, "R2");

    // R7 R8 high-power result via gap passes, indicator follows conv_pwr
    hold(100, 3, 0, "R7");
    hold(150, 3, 0, "R7");
    hold(120, 3, 0, "R7");
    hold(70, 3, 0, "R7");
    hold(150, 3, 0, "R7");
    hold(70, 3, 0, "R7");
    hold(500, 3, 0, "R8");
    hold(500, 2, 1, "R8");
    hold(500, 2, 0, "R8");
    hold(500, 2, 1, "R8");
    hold(10, 3, 1, "R8");

    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule